// File: doc/BRIEF.md
# SD card clock divider generator

This block derives the SD card clock from the fixed system clock. The clock passes through a cascade of two stages: an even prescaler, set by a field holding half its value (so 2 to 256 in powers of two when the block chooses it), and a linear divisor from 1 to 16, set by a field holding the divisor minus one. Both fields, together with three clock-enable bits, sit in one 32-bit control register. Software can write and read that register directly through a plain write strobe and a read bus.

The block can also choose the settings itself. A start pulse with a target frequency runs a small search state machine. The first thing it does is clear the clock field and all three enables, leaving every other register bit as it was. It then doubles the prescaler from 2 while the base frequency divided by the prescaler and by 16 still exceeds the target, stopping at 256. With the prescaler fixed, it steps the divisor up from 1 while the base frequency divided by both still exceeds the target, stopping at 16. Finally it writes the two fields and sets all three enables. A target of zero leaves the clock stopped.

The comparisons are made as products, so the block needs no divider, and the search takes one step per cycle. After every change to the register, a settle counter holds a status output low for a fixed number of cycles. A new setting reaches the card clock only at the end of the current output period.

Top module: `sdclk_gen`

## Requirements
- R1: While reset is held, the register reads 0, and the card clock, the settled status, the done pulse and busy are all low.
- R2: A write with busy low stores all 32 bits, and the register reads them back. The register layout is as follows:
  - bits [15:8] hold half the prescale value;
  - bits [7:4] hold the divisor minus one;
  - bit 0 is the interface clock enable, bit 1 the host clock enable and bit 2 the card clock enable.
- R3: A start pulse with busy low clears bits [15:4] and [2:0] on the next clock edge and leaves bit 3 and bits [31:16] unchanged. When the search completes, it writes both fields and sets bits [2:0] to 111.
- R4: A target of zero ends the search right after the clear. The fields and enables stay 0, done pulses and the card clock stays low.
- R5: The chosen prescaler P is the smallest power of two from 2 up for which floor(floor(BASE_HZ/P)/16) is not above the target, capped at 256.
- R6: With P chosen, the divisor D is the smallest value from 1 up for which floor(BASE_HZ/P/D) is not above the target, capped at 16. Any target below BASE_HZ/4096 therefore gives P=256 and D=16.
- R7: Done is high for exactly one cycle when a search completes. Writes and start pulses that arrive while busy is high have no effect.
- R8: While bit 2 is set, the card clock has a period of P*D system cycles and is high for the first P*D/2 of them. P is twice the prescaler field, and a field of 0 counts as P=2. While bit 2 is clear, the card clock is low.
- R9: A change of the fields while the clock runs takes effect only after the current card clock period has completed in full.
- R10: After any register write or any update by the search, the settled output is low for SETTLE_CYCLES cycles and then goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the base clock that is divided |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, ignored while busy |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Current register value |
| start | input | 1 | Starts a settings search for the target, ignored while busy |
| target | input | TGT_W | Desired card clock frequency in Hz |
| busy | output | 1 | The search is in progress |
| done | output | 1 | One-cycle pulse when a search completes |
| settled | output | 1 | The settle time since the last register change has elapsed |
| sd_clk | output | 1 | Divided card clock |

## Verification
The hardest case to reach is a change of the fields while the card clock is running. That change must not cut short the period already in progress. The stimulus first lets a search leave the clock running with an odd divisor. It then waits for a rising edge of the card clock and writes new fields a few cycles into that period. The bench checks that this period keeps its old length and high time, and that the following period has the new ones. The other hard case is a write or second start arriving in the middle of a search. The stimulus injects both in the cycle right after the start pulse, so they land in the first search step, and the scoreboard then expects the result of the first target only.

// File: rtl/sdclk_pkg.sv
// Shared constants and types for the SD card clock generator.
// Assumes a 32-bit control register with fixed field positions.
package sdclk_pkg;
    localparam int PRE_FIELD_W  = 8;
    localparam int DIV_FIELD_W  = 4;
    localparam int DIV_LSB      = 4;
    localparam int PRE_LSB      = DIV_LSB + DIV_FIELD_W;
    localparam int IF_EN_BIT    = 0;
    localparam int HOST_EN_BIT  = 1;
    localparam int CARD_EN_BIT  = 2;
    localparam int PRE_MAX      = 2 ** PRE_FIELD_W;
    localparam int DIV_MAX      = 2 ** DIV_FIELD_W;
    localparam logic [31:0] FIELD_EN_MASK = 32'h0000_FFF7;

    typedef enum logic [1:0] {
        S_IDLE,
        S_PRE,
        S_DIV
    } srch_state_t;
endpackage

// File: rtl/sdclk_search.sv
// Settings search: picks the prescaler, then the divisor, one step per cycle.
// Compares (target+1)*P*D against the base frequency, which matches the
// integer-division rule floor(BASE/P/D) > target without a divider.
module sdclk_search
    import sdclk_pkg::*;
#(
    parameter int unsigned BASE_HZ = 50_000_000,
    parameter int          TGT_W   = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [TGT_W-1:0]       target_i,
    output logic                   busy_o,
    output logic                   clr_o,
    output logic                   apply_o,
    output logic                   done_o,
    output logic [PRE_FIELD_W-1:0] pre_field_o,
    output logic [DIV_FIELD_W-1:0] div_field_o
);
    localparam int PW = PRE_FIELD_W + 1;
    localparam int DW = DIV_FIELD_W + 1;
    localparam int MW = TGT_W + 1 + PW + DW;

    srch_state_t     state_q;
    logic [TGT_W:0]  tgt_p1_q;
    logic [PW-1:0]   pre_q;
    logic [DW-1:0]   div_q;
    logic            done_q;
    logic [MW-1:0]   base_ext, prod_pre, prod_div;
    logic            step_pre, step_div;
    logic [DW-1:0]   div_m1;

    // Decide whether each stage must keep stepping.
    always_comb begin
        base_ext = MW'(BASE_HZ);
        prod_pre = MW'(tgt_p1_q) * MW'(pre_q) * MW'(DIV_MAX);
        prod_div = MW'(tgt_p1_q) * MW'(pre_q) * MW'(div_q);
        step_pre = (base_ext >= prod_pre) && (pre_q < PW'(PRE_MAX));
        step_div = (base_ext >= prod_div) && (div_q < DW'(DIV_MAX));
        div_m1   = div_q - DW'(1);
    end

    assign busy_o      = (state_q != S_IDLE);
    assign clr_o       = (state_q == S_IDLE) && start_i;
    assign apply_o     = (state_q == S_DIV) && !step_div;
    assign done_o      = done_q;
    assign pre_field_o = pre_q[PW-1:1];
    assign div_field_o = div_m1[DIV_FIELD_W-1:0];

    // Search sequencer: idle, prescaler doubling, divisor stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            tgt_p1_q <= '0;
            pre_q    <= PW'(2);
            div_q    <= DW'(1);
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                S_IDLE: if (start_i) begin
                    tgt_p1_q <= (TGT_W+1)'(target_i) + (TGT_W+1)'(1);
                    pre_q    <= PW'(2);
                    div_q    <= DW'(1);
                    if (target_i == '0) done_q  <= 1'b1;
                    else                state_q <= S_PRE;
                end
                S_PRE: begin
                    if (step_pre) pre_q <= pre_q << 1;
                    else          state_q <= S_DIV;
                end
                S_DIV: begin
                    if (step_div) div_q <= div_q + DW'(1);
                    else begin
                        state_q <= S_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sdclk_ctrl_reg.sv
// Control register and settle timer. Clear and apply come from the search
// and are never active together with an accepted write.
module sdclk_ctrl_reg
    import sdclk_pkg::*;
#(
    parameter int SETTLE_CYCLES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [31:0]            wr_data_i,
    input  logic                   clr_i,
    input  logic                   apply_i,
    input  logic [PRE_FIELD_W-1:0] pre_field_i,
    input  logic [DIV_FIELD_W-1:0] div_field_i,
    output logic [31:0]            reg_o,
    output logic                   settled_o
);
    localparam int CW = $clog2(SETTLE_CYCLES + 1);

    logic [31:0]   reg_q;
    logic [31:0]   applied;
    logic [CW-1:0] cnt_q;

    // Compose the register value that a completed search writes.
    always_comb begin
        applied = reg_q & ~FIELD_EN_MASK;
        applied[PRE_LSB +: PRE_FIELD_W] = pre_field_i;
        applied[DIV_LSB +: DIV_FIELD_W] = div_field_i;
        applied[IF_EN_BIT]   = 1'b1;
        applied[HOST_EN_BIT] = 1'b1;
        applied[CARD_EN_BIT] = 1'b1;
    end

    // Register update: search clear, search apply, or software write.
    always_ff @(posedge clk) begin
        if (!rst_n)       reg_q <= '0;
        else if (clr_i)   reg_q <= reg_q & ~FIELD_EN_MASK;
        else if (apply_i) reg_q <= applied;
        else if (wr_en_i) reg_q <= wr_data_i;
    end

    // Settle timer: reload on any update, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                            cnt_q <= CW'(SETTLE_CYCLES);
        else if (clr_i || apply_i || wr_en_i)  cnt_q <= CW'(SETTLE_CYCLES);
        else if (cnt_q != '0)                  cnt_q <= cnt_q - CW'(1);
    end

    assign reg_o     = reg_q;
    assign settled_o = (cnt_q == '0);
endmodule

// File: rtl/sdclk_divider.sv
// Prescaler and divisor cascade driving a registered card clock.
// Settings are shadowed and reloaded only at the end of an output period,
// or when the clock starts from stopped, so no shortened pulse appears.
module sdclk_divider
    import sdclk_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en_i,
    input  logic [PRE_FIELD_W-1:0] pre_field_i,
    input  logic [DIV_FIELD_W-1:0] div_field_i,
    output logic                   sd_clk_o
);
    localparam int PW = PRE_FIELD_W + 1;
    localparam int DW = DIV_FIELD_W + 1;

    logic [PRE_FIELD_W-1:0] pre_a;
    logic [DIV_FIELD_W-1:0] div_a;
    logic                   running;
    logic [PW-1:0]          pc;
    logic [DIV_FIELD_W-1:0] dc;
    logic                   sd_q;
    logic [PW-1:0]          pa, pa_half;
    logic [DW-1:0]          da, half_d, dc_ext;
    logic                   high, pc_last, dc_last;

    // Decode the active settings and the output level for this position.
    always_comb begin
        pa      = (pre_a == '0) ? PW'(2) : {pre_a, 1'b0};
        pa_half = pa >> 1;
        da      = {1'b0, div_a} + DW'(1);
        half_d  = da >> 1;
        dc_ext  = {1'b0, dc};
        high    = (dc_ext < half_d) ||
                  (da[0] && (dc_ext == half_d) && (pc < pa_half));
        pc_last = (pc == pa - PW'(1));
        dc_last = (dc == div_a);
    end

    // Position counters, shadow reload and registered output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            pc      <= '0;
            dc      <= '0;
            sd_q    <= 1'b0;
            pre_a   <= '0;
            div_a   <= '0;
        end else if (!en_i) begin
            running <= 1'b0;
            pc      <= '0;
            dc      <= '0;
            sd_q    <= 1'b0;
        end else if (!running) begin
            running <= 1'b1;
            pre_a   <= pre_field_i;
            div_a   <= div_field_i;
            sd_q    <= 1'b0;
        end else begin
            sd_q <= high;
            if (pc_last) begin
                pc <= '0;
                if (dc_last) begin
                    dc    <= '0;
                    pre_a <= pre_field_i;
                    div_a <= div_field_i;
                end else begin
                    dc <= dc + DIV_FIELD_W'(1);
                end
            end else begin
                pc <= pc + PW'(1);
            end
        end
    end

    assign sd_clk_o = sd_q;
endmodule

// File: rtl/sdclk_gen.sv
// Top of the SD card clock generator: register, search and divider.
// Assumes clk runs at BASE_HZ; writes and starts are dropped while busy.
module sdclk_gen
    import sdclk_pkg::*;
#(
    parameter int unsigned BASE_HZ       = 50_000_000,
    parameter int          TGT_W         = 32,
    parameter int          SETTLE_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    output logic [31:0]      rd_data,
    input  logic             start,
    input  logic [TGT_W-1:0] target,
    output logic             busy,
    output logic             done,
    output logic             settled,
    output logic             sd_clk
);
    logic                   clr_s, apply_s;
    logic [PRE_FIELD_W-1:0] pre_f;
    logic [DIV_FIELD_W-1:0] div_f;
    logic                   wr_ok;

    assign wr_ok = wr_en && !busy;

    sdclk_search #(.BASE_HZ(BASE_HZ), .TGT_W(TGT_W)) u_search (
        .clk(clk), .rst_n(rst_n), .start_i(start), .target_i(target),
        .busy_o(busy), .clr_o(clr_s), .apply_o(apply_s), .done_o(done),
        .pre_field_o(pre_f), .div_field_o(div_f)
    );

    sdclk_ctrl_reg #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_ok), .wr_data_i(wr_data),
        .clr_i(clr_s), .apply_i(apply_s), .pre_field_i(pre_f),
        .div_field_i(div_f), .reg_o(rd_data), .settled_o(settled)
    );

    sdclk_divider u_div (
        .clk(clk), .rst_n(rst_n), .en_i(rd_data[CARD_EN_BIT]),
        .pre_field_i(rd_data[PRE_LSB +: PRE_FIELD_W]),
        .div_field_i(rd_data[DIV_LSB +: DIV_FIELD_W]),
        .sd_clk_o(sd_clk)
    );
endmodule

// File: rtl/sdclk_gen_chk.sv
// Property checker for sdclk_gen, attached by bind below.
module sdclk_gen_chk #(
    parameter int TGT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [31:0]      rd_data,
    input logic             start,
    input logic [TGT_W-1:0] target,
    input logic             busy,
    input logic             done,
    input logic             settled,
    input logic             sd_clk,
    input logic             apply_s
);
    // R3: start clears fields and enables, keeps the other bits
    a_r3_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> ((rd_data & 32'h0000_FFF7) == 32'd0) &&
            ((rd_data & ~32'h0000_FFF7) == $past(rd_data & ~32'h0000_FFF7)));

    // R4: zero target leaves everything cleared and finishes at once
    a_r4_zero_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (target == '0)) |=>
            (((rd_data & 32'h0000_FFF7) == 32'd0) && done));

    // R5: applied prescaler field is a single power of two, enables all on
    a_r5_pow2_prescaler: assert property (@(posedge clk) disable iff (!rst_n)
        apply_s |=> (($countones(rd_data[15:8]) == 1) && (rd_data[2:0] == 3'b111)));

    // R7: done lasts one cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: writes during a search do not reach the register
    a_r7_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && !apply_s) |=> (rd_data == $past(rd_data)));

    // R8: card clock low while its enable is clear
    a_r8_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[2] |=> !sd_clk);

    // R10: a register change drops the settled status
    a_r10_settle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data != $past(rd_data)) |-> !settled);
endmodule

bind sdclk_gen sdclk_gen_chk #(.TGT_W(TGT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_data(rd_data),
    .start(start), .target(target), .busy(busy), .done(done),
    .settled(settled), .sd_clk(sd_clk), .apply_s(apply_s)
);

// File: tb/sdclk_gen_bench.sv
// Scoreboard bench: the driver queues predicted register values, the
// monitor compares them whenever done pulses.
module sdclk_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 50_000_000;
    localparam int SETTLE     = 16;
    localparam logic [31:0] MASK = 32'h0000_FFF7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        start = 1'b0;
    logic [31:0] target = '0;
    logic [31:0] rd_data;
    logic        busy, done, settled, sd_clk;

    int          n_vec = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;
    logic [31:0] exp_q[$];
    logic [31:0] model = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdclk_gen #(.BASE_HZ(BASE), .TGT_W(32), .SETTLE_CYCLES(SETTLE)) u_sdclk_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .start(start), .target(target), .busy(busy),
        .done(done), .settled(settled), .sd_clk(sd_clk)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected register after a search, from the selection rules.
    function automatic logic [31:0] predict(input logic [31:0] prev, input longint t);
        longint p = 2;
        longint d = 1;
        if (t == 0) return prev & ~MASK;
        while ((BASE / p / 16) > t && p < 256) p = p * 2;
        while ((BASE / p / d) > t && d < 16) d = d + 1;
        return (prev & ~MASK) | 32'((p / 2) << 8) | 32'((d - 1) << 4) | 32'h7;
    endfunction

    function automatic int exp_period(input logic [31:0] r);
        int p = (r[15:8] == 0) ? 2 : 2 * int'(r[15:8]);
        return p * (int'(r[7:4]) + 1);
    endfunction

    // Monitor: compare the register against the queue on each done.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) chk(1'b0, "R7 unexpected done", rd_data, '0);
            else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, "R5 R6 search result", rd_data, e);
            end
        end
    end

    task automatic run_search(input logic [31:0] t, input bit poke);
        logic [31:0] e;
        int k;
        e = predict(model, t);
        exp_q.push_back(e);
        start = 1'b1; target = t;
        @(negedge clk);
        start = 1'b0;
        chk(((rd_data & MASK) == 0) && ((rd_data & ~MASK) == (model & ~MASK)),
            "R3 cleared before apply", rd_data, model & ~MASK);
        if (poke) begin
            wr_en = 1'b1; wr_data = 32'hFFFF_FFFF; start = 1'b1; target = 32'd7;
            @(negedge clk);
            wr_en = 1'b0; start = 1'b0;
        end
        while (!done) @(negedge clk);
        chk(!settled, "R10 settled low at update", {31'd0, settled}, 32'd0);
        k = 0;
        while (!settled) begin
            @(negedge clk);
            k++;
            if (k == 1) chk(!done, "R7 done one cycle", {31'd0, done}, 32'd0);
        end
        chk(k == SETTLE, "R10 settle length", k, SETTLE);
        model = e;
    endtask

    task automatic wait_rise();
        logic prev;
        do begin
            prev = sd_clk;
            @(negedge clk);
        end while (!(sd_clk && !prev));
    endtask

    // Measure one period from a rise; optionally write a new value mid-way.
    task automatic period(output int p, output int h,
                          input bit do_wr, input logic [31:0] val);
        logic prev = 1'b1;
        h = 1; p = 0;
        forever begin
            if (do_wr && p == 4) begin wr_en = 1'b1; wr_data = val; end
            @(negedge clk);
            wr_en = 1'b0;
            p++;
            if (sd_clk && !prev) break;
            if (sd_clk) h++;
            prev = sd_clk;
        end
    endtask

    task automatic measure(input string tag);
        int p, h, e;
        e = exp_period(model);
        wait_rise();
        period(p, h, 1'b0, '0);
        chk(p == e, {tag, " period"}, p, e);
        chk(h == e / 2, {tag, " high time"}, h, e / 2);
    endtask

    task automatic stays_low(input int n, input string tag);
        int highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sd_clk) highs++;
        end
        chk(highs == 0, tag, highs, 0);
    endtask

    initial begin
        int p, h, e_old, e_new;
        logic [31:0] nv;
        repeat (3) @(negedge clk);
        chk(rd_data == 0, "R1 reset register", rd_data, 0);
        chk({sd_clk, settled, done, busy} == 4'b0, "R1 reset outputs",
            {28'd0, sd_clk, settled, done, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        wr_en = 1'b1; wr_data = 32'hA5C3_0318;
        @(negedge clk);
        wr_en = 1'b0;
        chk(rd_data == 32'hA5C3_0318, "R2 write readback", rd_data, 32'hA5C3_0318);
        model = rd_data;
        stays_low(40, "R8 card clock off when bit 2 clear");

        run_search(32'd25_000_000, 1'b0);
        measure("R8 target 25M");
        run_search(32'd10_000_000, 1'b0);
        measure("R8 target 10M");
        run_search(32'd1, 1'b0);
        chk(model[15:4] == 12'h80F, "R6 lowest clock fields", model, 32'h80F0);
        measure("R8 lowest clock");
        run_search(32'd400_000, 1'b0);
        run_search(32'd12_345_678, 1'b0);
        run_search(32'd60_000_000, 1'b0);
        run_search(32'd0, 1'b0);
        stays_low(40, "R4 zero target stops clock");
        run_search(32'd5_000_000, 1'b1);
        measure("R7 result after ignored poke");
        run_search(32'd3_000_000, 1'b0);

        e_old = exp_period(model);
        nv = (model & ~MASK) | 32'h0000_0317;
        e_new = exp_period(nv);
        wait_rise();
        period(p, h, 1'b1, nv);
        chk(p == e_old, "R9 old period completes", p, e_old);
        chk(h == e_old / 2, "R9 old high time kept", h, e_old / 2);
        period(p, h, 1'b0, '0);
        chk(p == e_new, "R9 new period", p, e_new);
        chk(h == e_new / 2, "R9 new high time", h, e_new / 2);
        chk(rd_data == nv, "R2 write while running", rd_data, nv);

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule